// File: doc/BRIEF.md
# Parity Bus Transceiver Channel with Error Register

This block is one channel of a bidirectional bus transceiver that turns an 8-bit data path into a 9-bit one by adding a parity line. Two active-low output enables choose the direction of transfer. When the B side is enabled, the A word is copied unchanged onto the B side, and a parity bit is generated so that the nine B-side bits carry an odd number of ones. When the A side is enabled, the B word is copied onto the A side, and the incoming parity bit is checked against the B data.

A failed parity check is captured on the rising clock edge in an error register. An active-low clear empties this register at once and takes priority over the clock. The register drives an open-collector style error line, modelled as a sink enable that pulls the line low only while an error is held.

When both enables are asserted, the block still transfers from A to B but drives inverted parity. This deliberately creates a parity error so that the receiving logic can be tested. Each bus is modelled as separate input, output and output-enable signals rather than tri-state pins.

Top module: `pxv_parity_xcvr`

## Requirements
- R1: With oe_b_n=0 and oe_a_n=1 (A to B), b_oe=1, par_oe=1 and a_oe=0. b_out equals a_in, and par_out makes the 9 bits {b_out, par_out} contain an odd number of ones.
- R2: With oe_a_n=0 and oe_b_n=1 (B to A), a_oe=1, b_oe=0 and par_oe=0, and a_out equals b_in.
- R3: With oe_a_n=1 and oe_b_n=1, a_oe, b_oe and par_oe are all 0, so both buses are isolated.
- R4: With oe_a_n=0 and oe_b_n=0 (forced error), b_oe=1, par_oe=1 and a_oe=0. b_out equals a_in, and par_out is inverted, so {b_out, par_out} contains an even number of ones.
- R5: At a rising clk edge in the B to A setting, the error register loads 1 exactly when {b_in, par_in} contains an even number of ones. err_sink=1 means the error line is pulled low; err_sink=0 means the line is released.
- R6: At a rising clk edge in any other enable setting, the error register loads 0 ("no error").
- R7: While clr_n is 0, err_sink is 0 without waiting for a clock edge, and a rising clk edge does not load the register. After reset, err_sink is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that loads the error register |
| clr_n | input | 1 | Asynchronous active-low clear of the error register |
| oe_a_n | input | 1 | Active-low enable of the A-side outputs |
| oe_b_n | input | 1 | Active-low enable of the B-side and parity outputs |
| a_in | input | DATA_W | Data received from the A bus |
| b_in | input | DATA_W | Data received from the B bus |
| par_in | input | 1 | Parity bit received with B data |
| a_out | output | DATA_W | Data driven onto the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_out | output | DATA_W | Data driven onto the B bus |
| b_oe | output | 1 | B bus drive enable |
| par_out | output | 1 | Parity bit driven with B data |
| par_oe | output | 1 | Parity line drive enable |
| err_sink | output | 1 | 1 pulls the open-collector error line low |

## Verification
Every one of the 256 A values is sent in all four enable settings. This separates correct odd-parity generation from inverted or missing parity, and shows that the forced-error setting differs from normal A to B transfer by exactly the parity bit. In the B to A setting, each B word is paired with both parity values, so every word appears once with good parity and once with bad parity; this tells a real checker apart from one that depends only on the data or only on the parity bit. Corrupted parity is also presented in the other enable settings, to confirm that it is sampled as no error. A clear applied mid-cycle and held across a clock edge carrying bad parity shows that the clear acts asynchronously and that it wins over the clock.

// File: rtl/pxv_pkg.sv
`timescale 1ns/1ps
package pxv_pkg;
   typedef enum logic [1:0] {
      XFER_ISOLATE = 2'b00,
      XFER_A2B     = 2'b01,
      XFER_B2A     = 2'b10,
      XFER_FORCE   = 2'b11
   } xfer_e;

   function automatic xfer_e decode_xfer(input logic en_a_n, input logic en_b_n);
      xfer_e m;
      case ({en_a_n, en_b_n})
         2'b10:   m = XFER_A2B;
         2'b01:   m = XFER_B2A;
         2'b00:   m = XFER_FORCE;
         default: m = XFER_ISOLATE;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/pxv_dir_decode.sv
`timescale 1ns/1ps
module pxv_dir_decode
   import pxv_pkg::*;
(
   input  logic  oe_a_n,
   input  logic  oe_b_n,
   output xfer_e mode,
   output logic  a_side_en,
   output logic  b_side_en
);
   always_comb begin
      mode      = decode_xfer(oe_a_n, oe_b_n);
      a_side_en = (mode == XFER_B2A);
      b_side_en = (mode == XFER_A2B) || (mode == XFER_FORCE);
   end
endmodule

// File: rtl/pxv_parity.sv
`timescale 1ns/1ps
module pxv_parity #(
   parameter int W    = 8,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] d,
   output logic         odd_ones
);
   if (W < 1) begin : g_bad_w
      $error("pxv_parity: W must be at least 1");
   end
   if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
      $error("pxv_parity: IMPL must be 0 or 1");
   end

   if (IMPL == 0) begin : g_reduce
      assign odd_ones = ^d;
   end else begin : g_chain
      logic [W:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign acc[i+1] = acc[i] ^ d[i];
      end
      assign odd_ones = acc[W];
   end
endmodule

// File: rtl/pxv_err_flag.sv
`timescale 1ns/1ps
module pxv_err_flag (
   input  logic clk,
   input  logic clr_n,
   input  logic err_next,
   output logic err_q
);
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) err_q <= 1'b0;
      else        err_q <= err_next;
   end
endmodule

// File: rtl/pxv_parity_xcvr.sv
`timescale 1ns/1ps
module pxv_parity_xcvr
   import pxv_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PAR_IMPL = 0
) (
   input  logic              clk,
   input  logic              clr_n,
   input  logic              oe_a_n,
   input  logic              oe_b_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              par_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe,
   output logic              par_out,
   output logic              par_oe,
   output logic              err_sink
);
   localparam int CHK_W = DATA_W + 1;

   if (DATA_W < 1) begin : g_bad_dw
      $error("pxv_parity_xcvr: DATA_W must be at least 1");
   end

   xfer_e mode;
   logic  a_side_en, b_side_en;
   logic  a_odd, chk_odd, err_next, err_q;

   pxv_dir_decode u_dir (
      .oe_a_n    (oe_a_n),
      .oe_b_n    (oe_b_n),
      .mode      (mode),
      .a_side_en (a_side_en),
      .b_side_en (b_side_en)
   );

   pxv_parity #(.W(DATA_W), .IMPL(PAR_IMPL)) u_gen (
      .d        (a_in),
      .odd_ones (a_odd)
   );

   pxv_parity #(.W(CHK_W), .IMPL(PAR_IMPL)) u_chk (
      .d        ({b_in, par_in}),
      .odd_ones (chk_odd)
   );

   always_comb begin
      a_out   = b_in;
      b_out   = a_in;
      a_oe    = a_side_en;
      b_oe    = b_side_en;
      par_oe  = b_side_en;
      // odd total needs parity = not(odd count); forced mode flips it
      par_out = (mode == XFER_FORCE) ? a_odd : ~a_odd;
      err_next = (mode == XFER_B2A) && !chk_odd;
   end

   pxv_err_flag u_err (
      .clk      (clk),
      .clr_n    (clr_n),
      .err_next (err_next),
      .err_q    (err_q)
   );

   assign err_sink = err_q;

   p_gen_odd_r1: assert property (@(posedge clk) disable iff (!clr_n)
      (!oe_b_n && oe_a_n) |-> (b_oe && par_oe && !a_oe && b_out == a_in && (^{b_out, par_out})));

   p_b2a_path_r2: assert property (@(posedge clk) disable iff (!clr_n)
      (!oe_a_n && oe_b_n) |-> (a_oe && !b_oe && !par_oe && a_out == b_in));

   p_isolate_r3: assert property (@(posedge clk) disable iff (!clr_n)
      (oe_a_n && oe_b_n) |-> !(a_oe || b_oe || par_oe));

   p_forced_even_r4: assert property (@(posedge clk) disable iff (!clr_n)
      (!oe_a_n && !oe_b_n) |-> (b_oe && par_oe && !a_oe && !(^{b_out, par_out})));

   p_err_load_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (!oe_a_n && oe_b_n) |=> (err_sink == !(^$past({b_in, par_in}))));

   p_err_idle_r6: assert property (@(posedge clk) disable iff (!clr_n)
      !(!oe_a_n && oe_b_n) |=> !err_sink);
endmodule

// File: tb/test_pxv_parity_xcvr.sv
`timescale 1ns/1ps
module test_pxv_parity_xcvr;
   logic       clk = 1'b0;
   logic       clr_n = 1'b0;
   logic       oe_a_n = 1'b1, oe_b_n = 1'b1;
   logic [7:0] a_in = '0, b_in = '0;
   logic       par_in = 1'b0;
   logic [7:0] a_out, b_out;
   logic       a_oe, b_oe, par_out, par_oe, err_sink;

   int    n_err = 0, n_chk = 0;
   bit    mflag = 1'b0;
   string err_req = "R6";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   pxv_parity_xcvr i_pxv_parity_xcvr (
      .clk(clk), .clr_n(clr_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
      .a_in(a_in), .b_in(b_in), .par_in(par_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
      .par_out(par_out), .par_oe(par_oe), .err_sink(err_sink)
   );

   // behavioural reference of the error register
   always @(posedge clk or negedge clr_n) begin
      if (!clr_n) mflag <= 1'b0;
      else if (!oe_a_n && oe_b_n) mflag <= ($countones({b_in, par_in}) % 2) == 0;
      else mflag <= 1'b0;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic oa, input logic ob, input logic [7:0] a,
                       input logic [7:0] b, input logic p);
      logic       ep;
      @(negedge clk);
      chk(err_sink === mflag, err_req, err_sink, mflag);
      oe_a_n = oa; oe_b_n = ob; a_in = a; b_in = b; par_in = p;
      #1;
      if (!ob && oa) begin
         ep = ($countones(a) % 2) == 0;
         chk({a_oe, b_oe, par_oe} === 3'b011 && b_out === a && par_out === ep, "R1",
             {a_oe, b_oe, par_oe, b_out, par_out}, {3'b011, a, ep});
      end else if (!oa && ob) begin
         chk({a_oe, b_oe, par_oe} === 3'b100 && a_out === b, "R2",
             {a_oe, b_oe, par_oe, a_out}, {3'b100, b});
      end else if (oa && ob) begin
         chk({a_oe, b_oe, par_oe} === 3'b000, "R3", {a_oe, b_oe, par_oe}, 0);
      end else begin
         ep = ($countones(a) % 2) == 1;
         chk({a_oe, b_oe, par_oe} === 3'b011 && b_out === a && par_out === ep, "R4",
             {a_oe, b_oe, par_oe, b_out, par_out}, {3'b011, a, ep});
      end
      err_req = (!oa && ob) ? "R5" : "R6";
   endtask

   initial begin
      #2_400_000;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(err_sink === 1'b0, "R7", err_sink, 0);             // reset state
      chk({a_oe, b_oe, par_oe} === 3'b000, "R3", {a_oe, b_oe, par_oe}, 0);
      @(negedge clk) clr_n = 1'b1;

      for (int m = 0; m < 4; m++)
         for (int v = 0; v < 256; v++)
            for (int p = 0; p < 2; p++)
               step(m[1], m[0], v[7:0], v[7:0] ^ 8'h5A, p[0]);

      // R7: asynchronous clear beats the clock
      step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0);                 // even -> error
      @(posedge clk); #2;
      chk(err_sink === 1'b1, "R5", err_sink, 1);
      clr_n = 1'b0; #1;
      chk(err_sink === 1'b0, "R7", err_sink, 0);
      @(posedge clk); #1;
      chk(err_sink === 1'b0, "R7", err_sink, 0);
      @(negedge clk) clr_n = 1'b1;
      step(1'b0, 1'b1, 8'h01, 8'h03, 1'b1);                 // three ones -> ok
      step(1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
      @(negedge clk);
      chk(err_sink === mflag, err_req, err_sink, mflag);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule